// File: doc/BRIEF.md
# Frame-Synchronous Window Register Bank

This block holds the per-window configuration of a five-window display overlay engine. Software writes always land in a shadow copy. On each vertical-sync pulse the shadow copy of every window moves into the active copy that the fetch and blend logic reads. Because of this, the display never sees a change part way through a frame.

Multi-register updates need more than frame alignment. Each window therefore has a hold bit in a shared control register. While a window's hold bit is set, a vsync leaves that window's active copy untouched. Software sets the hold bit, rewrites any number of the window's registers, and clears the bit. The whole set then becomes active together at the next vsync. Each window also has a fetch-channel enable that is staged and released in the same way as its other fields.

The register port accepts a write on every cycle and has no back-pressure. Reads are combinational. A view-select input chooses whether a read returns the shadow copy or the active copy. The active copies are also driven out on flat buses, one slice per window.

Top module: `disp_shadow_regs`

## Requirements
- R1: After reset, every shadow field, active field, hold bit and channel enable is zero, and every read returns zero.
- R2: A write updates only the shadow copy. A shadow read (`rd_active`=0) returns the new value on the cycle after the write. The active copy keeps its old value until a vsync.
- R3: A vsync pulse copies every field of each window whose hold bit is clear from shadow to active. The copy takes effect on the cycle after the pulse, and an active read (`rd_active`=1) returns it.
- R4: A vsync leaves a window's active fields unchanged while that window's hold bit is set.
- R5: Clearing a hold bit does not move anything on its own. The pending shadow values of that window become active at the next vsync that follows.
- R6: A register write in the same cycle as a vsync is kept in the shadow copy. The active copy takes the shadow value from before that write, and the new value becomes active at the following vsync.
- R7: Hold bits are not shadowed. They take effect on the cycle after the control write and read back the same in both views. A vsync in the same cycle as a control write is gated by the hold bits as they were before that write.
- R8: The channel enable of window w is bit 8+w of the control register. It is staged like any other window field: its shadow value moves to the active copy only at a vsync on which window w is not held.
- R9: Some registers are absent. Window 0 has no blend (alpha) register and no key register, and windows 3 and 4 have no area register. A write to an absent register is ignored, and both views read zero. The area register holds 24 bits, and its upper write bits are dropped.
- R10: Address map. `addr[5:3]` selects the window (0 to 4), and `addr[2:0]` selects the register: 0 start, 1 end, 2 top-left, 3 bottom-right, 4 area, 5 blend, 6 key, 7 mode. Mode bit 0 is the window enable and bits 4:1 are the format. The control register is at 0x38: bits 4:0 are the hold bits and bits 12:8 are the channel enables. Any other address reads zero, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync | input | 1 | One-cycle frame-boundary pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 6 | Read address |
| rd_active | input | 1 | 1: read active copy, 0: read shadow copy |
| rd_data | output | 32 | Read data (combinational) |
| act_start | output | 160 | Active buffer start address, 32 bits per window |
| act_stop | output | 160 | Active buffer end address, 32 bits per window |
| act_tl | output | 160 | Active top-left corner {y,x}, 32 bits per window |
| act_br | output | 160 | Active inclusive bottom-right corner {y,x}, 32 bits per window |
| act_area | output | 120 | Active area size, 24 bits per window |
| act_blend | output | 60 | Active blend value, 12 bits per window |
| act_key | output | 160 | Active key value, 32 bits per window |
| act_fmt | output | 20 | Active pixel format code, 4 bits per window |
| act_win_en | output | 5 | Active window enables |
| act_chan | output | 5 | Active fetch-channel enables |

## Verification
The bench focuses on the cycles where a write and a vsync meet. It checks a data write and a hold-bit write that each coincide with a vsync. A design that applied the write first would make the new data active a frame early, or would let a hold take effect one vsync too soon. It also checks the staging of a held window: the active copy must stay at zero across a vsync, and must still stay at zero after the hold is cleared until the next pulse. A design that loaded on the falling edge of the hold bit would fail that check. Absent registers, channel enables gated by their own window's hold bit, and unmapped addresses are checked through both read views and the channel output pins.

// File: rtl/disp_shadow_pkg.sv
package disp_shadow_pkg;

  localparam int DW       = 32;
  localparam int AREA_W   = 24;
  localparam int BLEND_W  = 12;
  localparam int FMT_W    = 4;
  localparam int AW       = 6;
  localparam int IDX_W    = 3;
  localparam int WSEL_W   = AW - IDX_W;
  localparam int CHAN_LSB = 8;
  localparam logic [WSEL_W-1:0] CTRL_WSEL = '1;

  typedef enum logic [IDX_W-1:0] {
    RI_START = 3'd0,
    RI_END   = 3'd1,
    RI_TL    = 3'd2,
    RI_BR    = 3'd3,
    RI_AREA  = 3'd4,
    RI_BLEND = 3'd5,
    RI_KEY   = 3'd6,
    RI_MODE  = 3'd7
  } reg_idx_e;

  typedef struct packed {
    logic [DW-1:0]      start;
    logic [DW-1:0]      stop;
    logic [DW-1:0]      tl;
    logic [DW-1:0]      br;
    logic [AREA_W-1:0]  area;
    logic [BLEND_W-1:0] blend;
    logic [DW-1:0]      key;
    logic [FMT_W-1:0]   fmt;
    logic               en;
    logic               chan;
  } win_regs_t;

  function automatic bit win_has_area(int w);
    return w < 3;
  endfunction

  function automatic bit win_has_blend(int w);
    return w != 0;
  endfunction

endpackage

// File: rtl/disp_ctrl_bank.sv
module disp_ctrl_bank
  import disp_shadow_pkg::*;
#(
  parameter int NWIN = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctrl_wr,
  input  logic [NWIN-1:0] hold_wdata,
  input  logic            vsync,
  output logic [NWIN-1:0] hold_q,
  output logic [NWIN-1:0] load
);

  // hold bits act immediately; they are never shadowed
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (ctrl_wr) begin
      hold_q <= hold_wdata;
    end
  end

  // a vsync loads only the windows that are not held this cycle
  always_comb begin
    load = vsync ? ~hold_q : '0;
  end

endmodule

// File: rtl/disp_win_bank.sv
module disp_win_bank
  import disp_shadow_pkg::*;
#(
  parameter bit HAS_AREA  = 1'b1,
  parameter bit HAS_BLEND = 1'b1,
  parameter bit HAS_KEY   = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_wr,
  input  reg_idx_e      idx,
  input  logic [DW-1:0] wdata,
  input  logic          chan_wr,
  input  logic          chan_val,
  input  logic          load,
  output win_regs_t     shd,
  output win_regs_t     act
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd <= '0;
    end else begin
      if (sel_wr) begin
        case (idx)
          RI_START: shd.start <= wdata;
          RI_END:   shd.stop  <= wdata;
          RI_TL:    shd.tl    <= wdata;
          RI_BR:    shd.br    <= wdata;
          RI_AREA:  if (HAS_AREA)  shd.area  <= wdata[AREA_W-1:0];
          RI_BLEND: if (HAS_BLEND) shd.blend <= wdata[BLEND_W-1:0];
          RI_KEY:   if (HAS_KEY)   shd.key   <= wdata;
          RI_MODE: begin
            shd.en  <= wdata[0];
            shd.fmt <= wdata[FMT_W:1];
          end
          default: ;
        endcase
      end
      if (chan_wr) begin
        shd.chan <= chan_val;
      end
    end
  end

  // the whole window moves in one edge, so a set is never split
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= '0;
    end else if (load) begin
      act <= shd;
    end
  end

endmodule

// File: rtl/disp_read_mux.sv
module disp_read_mux
  import disp_shadow_pkg::*;
#(
  parameter int NWIN = 5
) (
  input  win_regs_t       shd [NWIN],
  input  win_regs_t       act [NWIN],
  input  logic [NWIN-1:0] hold_q,
  input  logic [AW-1:0]   rd_addr,
  input  logic            rd_active,
  output logic [DW-1:0]   rd_data
);

  win_regs_t         view;
  logic [WSEL_W-1:0] wsel;
  reg_idx_e          idx;

  always_comb begin
    wsel    = rd_addr[AW-1:IDX_W];
    idx     = reg_idx_e'(rd_addr[IDX_W-1:0]);
    view    = '0;
    rd_data = '0;
    for (int i = 0; i < NWIN; i++) begin
      if (wsel == WSEL_W'(i)) begin
        view = rd_active ? act[i] : shd[i];
      end
    end
    if (wsel == CTRL_WSEL) begin
      if (idx == RI_START) begin
        for (int i = 0; i < NWIN; i++) begin
          rd_data[i]            = hold_q[i];
          rd_data[CHAN_LSB + i] = rd_active ? act[i].chan : shd[i].chan;
        end
      end
    end else begin
      case (idx)
        RI_START: rd_data = view.start;
        RI_END:   rd_data = view.stop;
        RI_TL:    rd_data = view.tl;
        RI_BR:    rd_data = view.br;
        RI_AREA:  rd_data = DW'(view.area);
        RI_BLEND: rd_data = DW'(view.blend);
        RI_KEY:   rd_data = view.key;
        RI_MODE:  rd_data = DW'({view.fmt, view.en});
        default:  rd_data = '0;
      endcase
    end
  end

endmodule

// File: rtl/disp_shadow_regs.sv
module disp_shadow_regs
  import disp_shadow_pkg::*;
#(
  parameter int NWIN = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   vsync,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [DW-1:0]          wr_data,
  input  logic [AW-1:0]          rd_addr,
  input  logic                   rd_active,
  output logic [DW-1:0]          rd_data,
  output logic [NWIN*DW-1:0]     act_start,
  output logic [NWIN*DW-1:0]     act_stop,
  output logic [NWIN*DW-1:0]     act_tl,
  output logic [NWIN*DW-1:0]     act_br,
  output logic [NWIN*AREA_W-1:0] act_area,
  output logic [NWIN*BLEND_W-1:0] act_blend,
  output logic [NWIN*DW-1:0]     act_key,
  output logic [NWIN*FMT_W-1:0]  act_fmt,
  output logic [NWIN-1:0]        act_win_en,
  output logic [NWIN-1:0]        act_chan
);

  logic [WSEL_W-1:0] wr_wsel;
  reg_idx_e          wr_idx;
  logic              ctrl_wr;
  logic [NWIN-1:0]   hold_q;
  logic [NWIN-1:0]   load;
  win_regs_t         shd [NWIN];
  win_regs_t         act [NWIN];
  logic [NWIN*DW-1:0] shd_start_f;

  assign wr_wsel = wr_addr[AW-1:IDX_W];
  assign wr_idx  = reg_idx_e'(wr_addr[IDX_W-1:0]);
  assign ctrl_wr = wr_en && (wr_wsel == CTRL_WSEL) && (wr_idx == RI_START);

  disp_ctrl_bank #(.NWIN(NWIN)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .hold_wdata (wr_data[NWIN-1:0]),
    .vsync      (vsync),
    .hold_q     (hold_q),
    .load       (load)
  );

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    logic sel_wr;
    assign sel_wr = wr_en && (wr_wsel == WSEL_W'(w));

    disp_win_bank #(
      .HAS_AREA  (win_has_area(w)),
      .HAS_BLEND (win_has_blend(w)),
      .HAS_KEY   (win_has_blend(w))
    ) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_wr   (sel_wr),
      .idx      (wr_idx),
      .wdata    (wr_data),
      .chan_wr  (ctrl_wr),
      .chan_val (wr_data[CHAN_LSB + w]),
      .load     (load[w]),
      .shd      (shd[w]),
      .act      (act[w])
    );

    assign act_start[w*DW +: DW]           = act[w].start;
    assign act_stop[w*DW +: DW]            = act[w].stop;
    assign act_tl[w*DW +: DW]              = act[w].tl;
    assign act_br[w*DW +: DW]              = act[w].br;
    assign act_area[w*AREA_W +: AREA_W]    = act[w].area;
    assign act_blend[w*BLEND_W +: BLEND_W] = act[w].blend;
    assign act_key[w*DW +: DW]             = act[w].key;
    assign act_fmt[w*FMT_W +: FMT_W]       = act[w].fmt;
    assign act_win_en[w]                   = act[w].en;
    assign act_chan[w]                     = act[w].chan;
    assign shd_start_f[w*DW +: DW]         = shd[w].start;
  end

  disp_read_mux #(.NWIN(NWIN)) u_rd (
    .shd       (shd),
    .act       (act),
    .hold_q    (hold_q),
    .rd_addr   (rd_addr),
    .rd_active (rd_active),
    .rd_data   (rd_data)
  );

endmodule

// File: rtl/disp_shadow_chk.sv
module disp_shadow_chk
  import disp_shadow_pkg::*;
#(
  parameter int NWIN = 5
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    vsync,
  input logic [NWIN-1:0]         hold_q,
  input logic [NWIN*DW-1:0]      shd_start,
  input logic [NWIN*DW-1:0]      act_start,
  input logic [NWIN*BLEND_W-1:0] act_blend,
  input logic [NWIN-1:0]         act_chan
);

  for (genvar w = 0; w < NWIN; w++) begin : g_chk
    // R2
    quiet_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vsync |=> $stable(act_start[w*DW +: DW]) && $stable(act_chan[w]));

    // R3
    frame_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vsync && !hold_q[w]) |=> act_start[w*DW +: DW] == $past(shd_start[w*DW +: DW]));

    // R4
    held_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold_q[w] |=> $stable(act_start[w*DW +: DW]));

    // R8
    held_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold_q[w] |=> $stable(act_chan[w]));
  end

  // R9
  no_blend_w0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_blend[BLEND_W-1:0] == '0);

endmodule

bind disp_shadow_regs disp_shadow_chk #(.NWIN(NWIN)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .vsync     (vsync),
  .hold_q    (hold_q),
  .shd_start (shd_start_f),
  .act_start (act_start),
  .act_blend (act_blend),
  .act_chan  (act_chan)
);

// File: tb/test_disp_shadow_regs.sv
module test_disp_shadow_regs;
  import disp_shadow_pkg::*;

  localparam int NWIN = 5;
  localparam logic [5:0] CTRL = 6'h38;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vsync = 1'b0;
  logic wr_en = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [5:0] rd_addr = '0;
  logic rd_active = 1'b0;
  logic [31:0] rd_data;
  logic [NWIN*DW-1:0] act_start, act_stop, act_tl, act_br, act_key;
  logic [NWIN*AREA_W-1:0] act_area;
  logic [NWIN*BLEND_W-1:0] act_blend;
  logic [NWIN*FMT_W-1:0] act_fmt;
  logic [NWIN-1:0] act_win_en, act_chan;

  always #10 clk = ~clk;

  disp_shadow_regs #(.NWIN(NWIN)) i_disp_shadow_regs (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_active(rd_active), .rd_data(rd_data),
    .act_start(act_start), .act_stop(act_stop), .act_tl(act_tl), .act_br(act_br),
    .act_area(act_area), .act_blend(act_blend), .act_key(act_key), .act_fmt(act_fmt),
    .act_win_en(act_win_en), .act_chan(act_chan)
  );

  typedef struct {
    logic [5:0]  addr;
    bit          act;
    bit          pin;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  function automatic logic [5:0] wa(int w, int idx);
    return {w[2:0], idx[2:0]};
  endfunction

  // driver side: push an expected read result
  task automatic expect_rd(logic [5:0] a, bit view, logic [31:0] e, string tag);
    item_t it;
    it.addr = a; it.act = view; it.pin = 1'b0; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic expect_chan(logic [31:0] e, string tag);
    item_t it;
    it.addr = '0; it.act = 1'b0; it.pin = 1'b1; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d, bit vs);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; vsync = vs;
    @(negedge clk);
    wr_en = 1'b0; vsync = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk);
    vsync = 1'b1;
    @(negedge clk);
    vsync = 1'b0;
  endtask

  // monitor: pops expectations and compares
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        logic [31:0] got;
        it = q.pop_front();
        rd_addr = it.addr;
        rd_active = it.act;
        #1;
        got = it.pin ? 32'(act_chan) : rd_data;
        n_cmp++;
        if (got !== it.exp) begin
          n_bad++;
          $display("FAIL %s addr=%h view=%0d got=%h exp=%h", it.tag, it.addr, it.act, got, it.exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    expect_rd(wa(1,0), 0, 32'h0, "R1 shadow start");
    expect_rd(wa(1,0), 1, 32'h0, "R1 active start");
    expect_rd(CTRL, 1, 32'h0, "R1 control");
    expect_chan(32'h0, "R1 chan pins");
    drain();

    // R2 writes land in shadow only
    wr(wa(1,0), 32'h0000_1000, 0);
    wr(wa(1,2), 32'h0014_000A, 0);
    wr(wa(1,3), 32'h0033_0049, 0);
    wr(wa(1,5), 32'h0000_0FFF, 0);
    wr(wa(1,7), 32'h0000_0007, 0);
    expect_rd(wa(1,0), 0, 32'h0000_1000, "R2 shadow start");
    expect_rd(wa(1,0), 1, 32'h0, "R2 active held");
    expect_rd(wa(1,7), 0, 32'h7, "R2 shadow mode");
    drain();

    // R3 vsync transfers
    pulse();
    expect_rd(wa(1,0), 1, 32'h0000_1000, "R3 start");
    expect_rd(wa(1,3), 1, 32'h0033_0049, "R3 bottom-right");
    expect_rd(wa(1,5), 1, 32'h0000_0FFF, "R3 blend");
    expect_rd(wa(1,7), 1, 32'h7, "R3 mode");
    drain();

    // R4 held window
    wr(CTRL, 32'h4, 0);
    wr(wa(2,0), 32'h0000_2000, 0);
    wr(wa(2,1), 32'h0000_2FFF, 0);
    pulse();
    expect_rd(wa(2,0), 1, 32'h0, "R4 start held");
    expect_rd(wa(2,1), 1, 32'h0, "R4 end held");
    expect_rd(wa(2,0), 0, 32'h0000_2000, "R4 shadow kept");
    expect_rd(CTRL, 0, 32'h4, "R7 hold immediate");
    drain();

    // R5 release then next vsync
    wr(CTRL, 32'h0, 0);
    expect_rd(wa(2,0), 1, 32'h0, "R5 no load on release");
    drain();
    pulse();
    expect_rd(wa(2,0), 1, 32'h0000_2000, "R5 start");
    expect_rd(wa(2,1), 1, 32'h0000_2FFF, "R5 end");
    drain();

    // R6 write coinciding with vsync
    wr(wa(1,0), 32'h0000_3333, 0);
    wr(wa(1,0), 32'h0000_4444, 1);
    expect_rd(wa(1,0), 1, 32'h0000_3333, "R6 old shadow active");
    expect_rd(wa(1,0), 0, 32'h0000_4444, "R6 new in shadow");
    drain();
    pulse();
    expect_rd(wa(1,0), 1, 32'h0000_4444, "R6 following vsync");
    drain();

    // R7 hold write coinciding with vsync
    wr(wa(3,0), 32'h0000_0055, 0);
    wr(CTRL, 32'h8, 1);
    expect_rd(wa(3,0), 1, 32'h0000_0055, "R7 pre-write hold gates");
    expect_rd(CTRL, 1, 32'h8, "R7 hold set");
    drain();
    wr(wa(3,0), 32'h0000_0066, 0);
    pulse();
    expect_rd(wa(3,0), 1, 32'h0000_0055, "R7 now held");
    drain();
    wr(CTRL, 32'h0, 0);
    pulse();
    expect_rd(wa(3,0), 1, 32'h0000_0066, "R5 released win3");
    drain();

    // R8 channel enables
    wr(CTRL, 32'h0000_1010, 0);
    pulse();
    expect_chan(32'h0, "R8 chan held");
    expect_rd(CTRL, 0, 32'h0000_1010, "R8 shadow view");
    expect_rd(CTRL, 1, 32'h0000_0010, "R8 active view");
    drain();
    wr(CTRL, 32'h0000_1000, 0);
    pulse();
    expect_chan(32'h10, "R8 chan live");
    expect_rd(CTRL, 1, 32'h0000_1000, "R8 active view");
    drain();

    // R9 absent registers
    wr(wa(0,5), 32'h0000_0FFF, 0);
    wr(wa(0,6), 32'h0000_1234, 0);
    wr(wa(3,4), 32'h0000_ABCD, 0);
    wr(wa(1,4), 32'hFF00_ABCD, 0);
    wr(wa(2,6), 32'hFFFF_FFFF, 0);
    pulse();
    expect_rd(wa(0,5), 0, 32'h0, "R9 win0 blend shadow");
    expect_rd(wa(0,5), 1, 32'h0, "R9 win0 blend active");
    expect_rd(wa(0,6), 1, 32'h0, "R9 win0 key");
    expect_rd(wa(3,4), 0, 32'h0, "R9 win3 area");
    expect_rd(wa(1,4), 1, 32'h00_ABCD, "R9 win1 area 24b");
    expect_rd(wa(2,6), 1, 32'hFFFF_FFFF, "R9 win2 key");
    drain();

    // R10 unmapped addresses
    wr(wa(5,0), 32'hDEAD_BEEF, 0);
    wr(6'h39, 32'hDEAD_BEEF, 0);
    expect_rd(wa(5,0), 0, 32'h0, "R10 window 5");
    expect_rd(6'h39, 0, 32'h0, "R10 control neighbour");
    expect_rd(wa(1,0), 0, 32'h0000_4444, "R10 no aliasing");
    expect_rd(CTRL, 0, 32'h0000_1000, "R10 control untouched");
    drain();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule